// File: doc/BRIEF.md
# Serial Control Port with Pointer Modes

This block is a write-only serial port that loads a small bank of 8-bit control registers. It samples one bit per rising edge of the serial clock. A frame opens with a start bit (the line idles low), followed by a write bit, a command/data flag and eight payload bits. Payload bit D0 arrives first and is the least significant bit of the payload byte.

Command frames address one device on a shared bus through a 4-bit device field, and carry a 4-bit instruction. The instructions clear the registers, arm an address load, or pick a sticky pointer mode: increment, decrement or hold. Data frames either load the register pointer, when an address load was armed just before, or write the register under the pointer. After such a write the pointer steps according to the mode.

An active-low power-down input holds the port in a disabled, known state. After power-down the port ignores data until a command for its own device arrives. The serial line has no handshake, so no back-pressure is possible: every frame is taken in full at the bit rate, and the port is always ready. Read-back and arbitration are not provided.

Top module: `scp_port`

## Requirements
- R1: A frame is a 1 start bit on an idle-low line, then WR, then the flag (1 = command, 0 = data), then D0..D7, with D0 as payload bit 0. A frame with WR = 0 changes nothing.
- R2: While pdn_n is low, ptr_o is 0, mode_o is hold, active_o is 0 and every register holds RST_VAL.
- R3: After power-down, data frames are ignored until a command frame with the matching device code arrives, with any instruction. That frame sets active_o to 1, and active_o stays 1 until the next power-down.
- R4: A command frame whose device field (payload bits 3:0) differs from DEV_CODE is ignored entirely. It also leaves any armed address load in place.
- R5: The instruction is payload bits 7:4: 0 and 15 = clear, 1 = address select, 2 = no-op, 3 = increment mode, 4 = decrement mode, 5 = hold mode. Every other code acts as a no-op.
- R6: The clear instruction sets every register to RST_VAL and leaves the pointer and the mode unchanged.
- R7: After an address select, the next data frame loads the payload into the pointer when the payload is below NREG, and leaves the pointer unchanged otherwise. That frame writes no register. Any other matching command in between cancels the armed load.
- R8: mode_o is 0 for hold, 1 for increment and 2 for decrement. It changes only on the three mode instructions.
- R9: A data frame that is not an address load writes the payload to the register at ptr_o. The pointer then steps by +1 in increment mode or -1 in decrement mode, wrapping modulo NREG, and stays put in hold mode.
- R10: Registers, pointer, mode and active_o change only on the clock edge that samples D7 of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; bits are sampled on its rising edge |
| pdn_n | input | 1 | Active-low power-down, asynchronous |
| sdi | input | 1 | Serial data line, idles low |
| regs_o | output | NREG*8 | Register bank, register i in bits [8i+7:8i] |
| ptr_o | output | PTR_W | Current register pointer |
| mode_o | output | 2 | Pointer mode: 0 hold, 1 increment, 2 decrement |
| active_o | output | 1 | Port enabled by a matching command |

## Verification
The bench builds the port with NREG = 6, DEV_CODE = 5 and RST_VAL = 0x3C. Because six is not a power of two, both wrap directions go through the explicit modulo boundary rather than a free-running counter rollover. An address load of 9 then falls out of range, and cleared registers are told apart from written zero values. A behavioural model runs alongside and is compared with all outputs at every clock, while directed checks pin the cases named in the requirements.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int PAYLOAD_W  = 8;
  localparam int FRAME_BITS = PAYLOAD_W + 2;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_INC  = 2'd1,
    MODE_DEC  = 2'd2
  } ptr_mode_e;

  localparam logic [3:0] OP_CLEAR_A = 4'd0;
  localparam logic [3:0] OP_ASEL    = 4'd1;
  localparam logic [3:0] OP_INC     = 4'd3;
  localparam logic [3:0] OP_DEC     = 4'd4;
  localparam logic [3:0] OP_HOLD    = 4'd5;
  localparam logic [3:0] OP_CLEAR_B = 4'd15;

  typedef struct packed {
    logic                 wr;
    logic                 is_cmd;
    logic [PAYLOAD_W-1:0] payload;
  } frame_t;

  typedef struct packed {
    logic      activate;
    logic      clear;
    logic      mode_we;
    ptr_mode_e mode_new;
    logic      arm_set;
    logic      arm_clr;
    logic      addr_ld;
    logic      reg_we;
  } action_t;
endpackage

// File: rtl/scp_deser.sv
module scp_deser
  import scp_pkg::*;
(
  input  logic   clk,
  input  logic   pdn_n,
  input  logic   sdi,
  output logic   fire,
  output frame_t frm
);
  localparam int LAST  = FRAME_BITS - 1;
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [LAST-1:0]  shreg;

  always_ff @(posedge clk or negedge pdn_n) begin
    if (!pdn_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
    end else if (!busy) begin
      if (sdi) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == CNT_W'(LAST)) begin
      busy <= 1'b0;
    end else begin
      shreg[cnt] <= sdi;
      cnt        <= cnt + 1'b1;
    end
  end

  // The last payload bit is taken straight from the line so that the
  // frame acts on the same edge that samples it.
  assign fire        = busy && (cnt == CNT_W'(LAST));
  assign frm.wr      = shreg[0];
  assign frm.is_cmd  = shreg[1];
  assign frm.payload = {sdi, shreg[LAST-1:2]};
endmodule

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'h5
) (
  input  logic    fire,
  input  frame_t  frm,
  input  logic    active_i,
  input  logic    armed_i,
  output action_t act
);
  logic       cmd_hit;
  logic       data_ok;
  logic [3:0] op;

  always_comb begin
    op      = frm.payload[7:4];
    cmd_hit = fire && frm.wr && frm.is_cmd && (frm.payload[3:0] == DEV_CODE);
    data_ok = fire && frm.wr && !frm.is_cmd && active_i;

    act          = '0;
    act.mode_new = MODE_HOLD;
    act.activate = cmd_hit;
    act.clear    = cmd_hit && ((op == OP_CLEAR_A) || (op == OP_CLEAR_B));
    act.arm_set  = cmd_hit && (op == OP_ASEL);
    act.arm_clr  = (cmd_hit && (op != OP_ASEL)) || (data_ok && armed_i);
    act.addr_ld  = data_ok && armed_i;
    act.reg_we   = data_ok && !armed_i;
    if (cmd_hit) begin
      unique case (op)
        OP_INC:  begin act.mode_we = 1'b1; act.mode_new = MODE_INC;  end
        OP_DEC:  begin act.mode_we = 1'b1; act.mode_new = MODE_DEC;  end
        OP_HOLD: begin act.mode_we = 1'b1; act.mode_new = MODE_HOLD; end
        default: act.mode_we = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/scp_ptr.sv
module scp_ptr
  import scp_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int PTR_W = 3
) (
  input  logic                 clk,
  input  logic                 pdn_n,
  input  action_t              act,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic [PTR_W-1:0]     ptr,
  output ptr_mode_e            mode,
  output logic                 active,
  output logic                 armed
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(NREG - 1);

  logic in_range;
  assign in_range = ({1'b0, payload} < 9'(NREG));

  always_ff @(posedge clk or negedge pdn_n) begin
    if (!pdn_n) begin
      ptr    <= '0;
      mode   <= MODE_HOLD;
      active <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (act.activate) active <= 1'b1;
      if (act.arm_set)      armed <= 1'b1;
      else if (act.arm_clr) armed <= 1'b0;
      if (act.mode_we) mode <= act.mode_new;
      if (act.addr_ld && in_range) begin
        ptr <= payload[PTR_W-1:0];
      end else if (act.reg_we) begin
        unique case (mode)
          MODE_INC: ptr <= (ptr == TOP) ? '0 : ptr + 1'b1;
          MODE_DEC: ptr <= (ptr == '0) ? TOP : ptr - 1'b1;
          default:  ptr <= ptr;
        endcase
      end
    end
  end
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank
  import scp_pkg::*;
#(
  parameter int                   NREG    = 8,
  parameter int                   PTR_W   = 3,
  parameter logic [PAYLOAD_W-1:0] RST_VAL = '0
) (
  input  logic                      clk,
  input  logic                      pdn_n,
  input  logic                      clear,
  input  logic                      we,
  input  logic [PTR_W-1:0]          waddr,
  input  logic [PAYLOAD_W-1:0]      wdata,
  output logic [NREG*PAYLOAD_W-1:0] regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) begin
        regs[i*PAYLOAD_W +: PAYLOAD_W] <= RST_VAL;
      end else if (clear) begin
        regs[i*PAYLOAD_W +: PAYLOAD_W] <= RST_VAL;
      end else if (we && (waddr == PTR_W'(i))) begin
        regs[i*PAYLOAD_W +: PAYLOAD_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/scp_port.sv
module scp_port
  import scp_pkg::*;
#(
  parameter int          NREG     = 8,
  parameter logic [3:0]  DEV_CODE = 4'h5,
  parameter logic [7:0]  RST_VAL  = 8'h00,
  localparam int         PTR_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                 sclk,
  input  logic                 pdn_n,
  input  logic                 sdi,
  output logic [NREG*8-1:0]    regs_o,
  output logic [PTR_W-1:0]     ptr_o,
  output logic [1:0]           mode_o,
  output logic                 active_o
);
  logic      frame_fire;
  frame_t    frame;
  action_t   act;
  ptr_mode_e mode;
  logic      armed;

  scp_deser u_deser (
    .clk  (sclk),
    .pdn_n(pdn_n),
    .sdi  (sdi),
    .fire (frame_fire),
    .frm  (frame)
  );

  scp_decode #(.DEV_CODE(DEV_CODE)) u_decode (
    .fire    (frame_fire),
    .frm     (frame),
    .active_i(active_o),
    .armed_i (armed),
    .act     (act)
  );

  scp_ptr #(.NREG(NREG), .PTR_W(PTR_W)) u_ptr (
    .clk    (sclk),
    .pdn_n  (pdn_n),
    .act    (act),
    .payload(frame.payload),
    .ptr    (ptr_o),
    .mode   (mode),
    .active (active_o),
    .armed  (armed)
  );

  scp_regbank #(.NREG(NREG), .PTR_W(PTR_W), .RST_VAL(RST_VAL)) u_bank (
    .clk  (sclk),
    .pdn_n(pdn_n),
    .clear(act.clear),
    .we   (act.reg_we),
    .waddr(ptr_o),
    .wdata(frame.payload),
    .regs (regs_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/scp_port_chk.sv
module scp_port_chk #(
  parameter int NREG  = 8,
  parameter int PTR_W = 3
) (
  input logic              sclk,
  input logic              pdn_n,
  input logic              fire,
  input logic [NREG*8-1:0] regs_o,
  input logic [PTR_W-1:0]  ptr_o,
  input logic [1:0]        mode_o,
  input logic              active_o
);
  logic seen;
  always_ff @(posedge sclk or negedge pdn_n) begin
    if (!pdn_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R8
  mode_code_chk: assert property (@(posedge sclk) disable iff (!pdn_n)
    mode_o != 2'd3);

  // R9
  ptr_range_chk: assert property (@(posedge sclk) disable iff (!pdn_n)
    {1'b0, ptr_o} < (PTR_W+1)'(NREG));

  // R10
  quiet_between_chk: assert property (@(posedge sclk) disable iff (!pdn_n)
    seen && !fire |=> $stable(regs_o) && $stable(ptr_o) && $stable(mode_o) && $stable(active_o));

  // R3
  locked_regs_chk: assert property (@(posedge sclk) disable iff (!pdn_n)
    seen && !active_o |=> active_o || $stable(regs_o));

  // R3
  active_sticky_chk: assert property (@(posedge sclk) disable iff (!pdn_n)
    active_o |=> active_o);
endmodule

bind scp_port scp_port_chk #(.NREG(NREG), .PTR_W(PTR_W)) u_chk (
  .sclk    (sclk),
  .pdn_n   (pdn_n),
  .fire    (frame_fire),
  .regs_o  (regs_o),
  .ptr_o   (ptr_o),
  .mode_o  (mode_o),
  .active_o(active_o)
);

// File: tb/scp_port_test.sv
module scp_port_test;
  localparam int         NREG  = 6;
  localparam logic [7:0] RSTV  = 8'h3C;
  localparam int         DEV   = 5;
  localparam int         PTR_W = $clog2(NREG);

  logic              sclk = 1'b0;
  logic              pdn_n = 1'b1;
  logic              sdi = 1'b0;
  logic [NREG*8-1:0] regs;
  logic [PTR_W-1:0]  ptr;
  logic [1:0]        mode;
  logic              active;

  int tests = 0;
  int failed = 0;
  bit go = 0;
  bit done = 0;
  logic [7:0] pre_reg0;

  always #2 sclk = ~sclk;

  scp_port #(.NREG(NREG), .DEV_CODE(4'(DEV)), .RST_VAL(RSTV)) uut (
    .sclk(sclk), .pdn_n(pdn_n), .sdi(sdi),
    .regs_o(regs), .ptr_o(ptr), .mode_o(mode), .active_o(active)
  );

  // behavioural reference
  int m_reg [NREG];
  int m_ptr = 0, m_mode = 0;
  bit m_active = 0, m_arm = 0, in_frame = 0;
  bit bitq [$];

  function automatic void model_reset();
    foreach (m_reg[i]) m_reg[i] = RSTV;
    m_ptr = 0; m_mode = 0; m_active = 0; m_arm = 0; in_frame = 0;
    bitq.delete();
  endfunction

  function automatic void model_frame();
    int pay = 0;
    for (int i = 0; i < 8; i++) pay += int'(bitq[2+i]) << i;
    if (!bitq[0]) return;
    if (bitq[1]) begin
      if ((pay & 15) != DEV) return;
      m_active = 1;
      m_arm = ((pay >> 4) == 1);
      case (pay >> 4)
        0, 15: foreach (m_reg[i]) m_reg[i] = RSTV;
        3: m_mode = 1;
        4: m_mode = 2;
        5: m_mode = 0;
        default: ;
      endcase
    end else if (m_active) begin
      if (m_arm) begin
        if (pay < NREG) m_ptr = pay;
        m_arm = 0;
      end else begin
        m_reg[m_ptr] = pay;
        if (m_mode == 1) m_ptr = (m_ptr + 1) % NREG;
        if (m_mode == 2) m_ptr = (m_ptr + NREG - 1) % NREG;
      end
    end
  endfunction

  always @(posedge sclk or negedge pdn_n) begin
    if (!pdn_n) model_reset();
    else if (!in_frame) begin
      if (sdi) begin in_frame = 1; bitq.delete(); end
    end else begin
      bitq.push_back(sdi);
      if (bitq.size() == 10) begin model_frame(); in_frame = 0; end
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge sclk) begin
    if (go && !done) begin
      for (int i = 0; i < NREG; i++) chk("R9 model reg", int'(regs[i*8 +: 8]), m_reg[i]);
      chk("R7 model ptr", int'(ptr), m_ptr);
      chk("R8 model mode", int'(mode), m_mode);
      chk("R3 model active", int'(active), int'(m_active));
    end
  end

  function automatic int rg(int i);
    return int'(regs[i*8 +: 8]);
  endfunction

  task automatic send(bit wr, bit flag, logic [7:0] pay);
    @(negedge sclk) sdi <= 1'b1;
    @(negedge sclk) sdi <= wr;
    @(negedge sclk) sdi <= flag;
    for (int i = 0; i < 8; i++) @(negedge sclk) sdi <= pay[i];
    #0 pre_reg0 = regs[7:0];
    @(negedge sclk) sdi <= 1'b0;
  endtask

  task automatic cmd(logic [3:0] op, logic [3:0] dev = 4'(DEV));
    send(1'b1, 1'b1, {op, dev});
  endtask

  task automatic data(logic [7:0] v);
    send(1'b1, 1'b0, v);
  endtask

  initial begin
    #1 pdn_n = 1'b0;
    repeat (3) @(negedge sclk);
    go = 1;
    chk("R2 ptr", int'(ptr), 0);
    chk("R2 mode", int'(mode), 0);
    chk("R2 active", int'(active), 0);
    chk("R2 reg0", rg(0), RSTV);
    pdn_n = 1'b1;
    @(negedge sclk);

    data(8'h11);
    chk("R3 locked reg0", rg(0), RSTV);
    cmd(4'd2, 4'd3);
    chk("R4 foreign cmd", int'(active), 0);
    cmd(4'd2);
    chk("R3 nop enables", int'(active), 1);

    data(8'h11);
    chk("R9 hold write", rg(0), 8'h11);
    chk("R9 hold ptr", int'(ptr), 0);
    chk("R10 before D7 edge", int'(pre_reg0), 8'h3C);

    cmd(4'd3);
    chk("R8 inc mode", int'(mode), 1);
    data(8'h22);
    chk("R9 inc write", rg(0), 8'h22);
    chk("R9 inc ptr", int'(ptr), 1);

    cmd(4'd1);
    cmd(4'd2, 4'd7);
    data(8'h05);
    chk("R7 addr load", int'(ptr), 5);
    chk("R4 arm kept", rg(5), RSTV);
    data(8'h33);
    chk("R9 write top", rg(5), 8'h33);
    chk("R9 wrap up", int'(ptr), 0);

    cmd(4'd4);
    data(8'h44);
    chk("R9 dec write", rg(0), 8'h44);
    chk("R9 wrap down", int'(ptr), 5);

    cmd(4'd1);
    data(8'h09);
    chk("R7 out of range", int'(ptr), 5);
    chk("R7 no write", rg(5), 8'h33);
    data(8'h55);
    chk("R9 after load", rg(5), 8'h55);
    chk("R9 dec step", int'(ptr), 4);

    cmd(4'd1);
    cmd(4'd2);
    data(8'h01);
    chk("R7 cancelled", rg(4), 8'h01);
    chk("R7 cancelled ptr", int'(ptr), 3);

    send(1'b0, 1'b0, 8'h77);
    chk("R1 wr0 reg", rg(3), RSTV);
    chk("R1 wr0 ptr", int'(ptr), 3);

    cmd(4'd7);
    chk("R5 unassigned", int'(mode), 2);
    cmd(4'd0);
    chk("R6 clear reg0", rg(0), RSTV);
    chk("R6 clear reg5", rg(5), RSTV);
    chk("R6 ptr kept", int'(ptr), 3);
    chk("R6 mode kept", int'(mode), 2);
    data(8'h66);
    cmd(4'd15);
    chk("R5 code15 clear", rg(3), RSTV);
    cmd(4'd5);
    chk("R8 hold mode", int'(mode), 0);

    @(negedge sclk) pdn_n = 1'b0;
    #1;
    chk("R2 pdn ptr", int'(ptr), 0);
    chk("R2 pdn active", int'(active), 0);
    @(negedge sclk) pdn_n = 1'b1;
    data(8'h99);
    chk("R3 relocked", rg(0), RSTV);
    cmd(4'd2);
    data(8'h99);
    chk("R3 reenabled", rg(0), 8'h99);

    repeat (2) @(negedge sclk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      tests++;
      failed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule